// File: doc/BRIEF.md
# Load-Use Interlock and Bypass Controller

This block is the hazard controller for an in-order pipeline with nine stages. The stages are two fetch stages, two decode stages, register read (RR), ALU, two data-memory stages (M1, M2) and write-back (WB). Every instruction occupies one slot per stage as it moves down the pipe. An ALU instruction does not use the memory stages: its result is final at the end of ALU and reaches the register file while the instruction sits in the M1 slot. A load result is final only at the end of M2 and reaches the register file while the load sits in WB.

Each cycle the block compares the enabled, non-zero source registers of the instruction in the second decode stage with the destinations of the valid, writing instructions in RR, ALU, M1, M2 and WB. For each source only the youngest matching producer counts. When an operand cannot be supplied in time, the block freezes both fetch stages and both decode stages, and a bubble enters RR instead of the held instruction. Every stall cycle is one extra cycle of run time.

The parameter `BYPASS_EN` selects whether a forwarding network into the ALU exists. When it does, the block also produces, for each operand of the instruction now in the ALU stage, a code that tells the datapath which pipeline latch to take the operand from.

Top module: `ldu_hazard_ctrl`

## Requirements
- R1: A source is considered only when `de2_valid_i` is high, its enable bit is high and its register number is non-zero. A producer stage is considered only when its valid and write-enable bits are both high. Stage bit order in every stage vector is 0=RR, 1=ALU, 2=M1, 3=M2, 4=WB.
- R2: With `BYPASS_EN`=0, a matching load in RR, ALU, M1 or M2 stalls. A matching load in WB does not stall. A dependent instruction directly behind a load gets 4 bubbles.
- R3: With `BYPASS_EN`=0, a matching ALU instruction in RR or ALU stalls, and one in M1 or later does not. ALU-to-ALU back to back costs 2 bubbles, and 1 bubble with one instruction in between.
- R4: With `BYPASS_EN`=1, a matching load in RR or ALU stalls and a matching load in M1 is forwarded. A dependent instruction directly behind a load gets 2 bubbles, and 1 bubble with one instruction in between.
- R5: With `BYPASS_EN`=1, a matching load in M2 stalls for one cycle, and the operand then comes from the register file.
- R6: With `BYPASS_EN`=1, a matching ALU producer never stalls. The operand comes from M1 (code 1) when the producer was one slot ahead, and from M2 (code 2) when it was two slots ahead.
- R7: When several stages match a source, only the youngest (lowest stage index) decides both stall and forwarding.
- R8: `fetch_hold_o`, `decode_hold_o` and `rr_bubble_o` are high in exactly the cycles in which a hazard is detected, in the same cycle, without a register.
- R9: `ex_fwd_sel_o` codes are 0=register file, 1=M1 latch, 2=M2 latch, 3=WB latch (load data). The code for an operand appears two clock edges after its instruction leaves decode, that is, while the instruction is in the ALU stage. A bubble carries code 0, and reset clears all codes to 0.
- R10: With `BYPASS_EN`=0, `ex_fwd_sel_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| de2_valid_i | input | 1 | Second decode stage holds an instruction |
| de2_src_i | input | NUM_SRC*AW | Source register numbers of the decode instruction |
| de2_src_en_i | input | NUM_SRC | Source is actually read |
| stg_valid_i | input | 5 | Valid per downstream stage (RR..WB) |
| stg_we_i | input | 5 | Register write enable per stage |
| stg_ld_i | input | 5 | Stage holds a load |
| stg_rd_i | input | 5*AW | Destination register per stage |
| fetch_hold_o | output | 1 | Freeze both fetch stages |
| decode_hold_o | output | 1 | Freeze both decode stages |
| rr_bubble_o | output | 1 | Inject a bubble into register read |
| ex_fwd_sel_o | output | NUM_SRC*2 | Operand source code per operand in the ALU stage |

## Verification
The bench builds two copies side by side, one with `BYPASS_EN`=0 and one with `BYPASS_EN`=1, both with AW=5 and two sources. A small pipeline model in the bench drives each copy with the same instruction sequences, so every load-use and ALU-use distance yields a bubble count for each mode. This brings the 4-versus-2 load penalty, the single-bubble load-in-M2 case and the youngest-producer rule into reach, and the bench also observes the forwarding code in the cycle the consumer reaches the ALU stage.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned NUM_STG = 5;
  localparam int unsigned STG_RR  = 0;
  localparam int unsigned STG_EX  = 1;
  localparam int unsigned STG_M1  = 2;
  localparam int unsigned STG_M2  = 3;
  localparam int unsigned STG_WB  = 4;

  typedef enum logic [1:0] {
    FWD_RF = 2'd0,
    FWD_M1 = 2'd1,
    FWD_M2 = 2'd2,
    FWD_WB = 2'd3
  } fwd_sel_e;
endpackage

// File: rtl/hzd_src_chk.sv
module hzd_src_chk
  import hzd_pkg::*;
#(
  parameter int unsigned AW        = 5,
  parameter bit          BYPASS_EN = 1'b1
) (
  input  logic                            de_valid_i,
  input  logic                            src_en_i,
  input  logic [AW-1:0]                   src_i,
  input  logic [NUM_STG-1:0]              stg_valid_i,
  input  logic [NUM_STG-1:0]              stg_we_i,
  input  logic [NUM_STG-1:0]              stg_ld_i,
  input  logic [NUM_STG-1:0][AW-1:0]      stg_rd_i,
  output logic                            stall_o,
  output fwd_sel_e                        sel_o
);
  localparam int unsigned IW = $clog2(NUM_STG);

  logic               src_live;
  logic [NUM_STG-1:0] hit;
  logic               any_hit;
  logic               hit_ld;
  logic [IW-1:0]      hit_idx;

  assign src_live = de_valid_i & src_en_i & (src_i != '0);

  for (genvar g = 0; g < NUM_STG; g++) begin : g_cmp
    assign hit[g] = src_live & stg_valid_i[g] & stg_we_i[g] & (stg_rd_i[g] == src_i);
  end

  // youngest producer wins: scan oldest to youngest, last write stays
  always_comb begin
    any_hit = |hit;
    hit_idx = '0;
    hit_ld  = 1'b0;
    for (int k = int'(NUM_STG) - 1; k >= 0; k--) begin
      if (hit[k]) begin
        hit_idx = IW'(k);
        hit_ld  = stg_ld_i[k];
      end
    end
  end

  if (BYPASS_EN) begin : g_byp
    always_comb begin
      stall_o = 1'b0;
      sel_o   = FWD_RF;
      if (any_hit) begin
        if (hit_ld) begin
          stall_o = (hit_idx == IW'(STG_RR)) || (hit_idx == IW'(STG_EX)) ||
                    (hit_idx == IW'(STG_M2));
          if (hit_idx == IW'(STG_M1)) sel_o = FWD_WB;
        end else begin
          if (hit_idx == IW'(STG_RR))      sel_o = FWD_M1;
          else if (hit_idx == IW'(STG_EX)) sel_o = FWD_M2;
        end
      end
    end
  end else begin : g_nobyp
    assign sel_o   = FWD_RF;
    assign stall_o = any_hit & (hit_ld ? (hit_idx <= IW'(STG_M2))
                                       : (hit_idx <= IW'(STG_EX)));
  end
endmodule

// File: rtl/hzd_fwd_pipe.sv
module hzd_fwd_pipe #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    adv_i,
  input  logic [NUM_SRC-1:0][1:0] sel_de_i,
  output logic [NUM_SRC-1:0][1:0] sel_ex_o
);
  logic [NUM_SRC-1:0][1:0] sel_rr_q;
  logic [NUM_SRC-1:0][1:0] sel_ex_q;

  // RR gets a zero code on a bubble; RR to ALU always advances
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_rr_q <= '0;
      sel_ex_q <= '0;
    end else begin
      sel_rr_q <= adv_i ? sel_de_i : '0;
      sel_ex_q <= sel_rr_q;
    end
  end

  assign sel_ex_o = sel_ex_q;
endmodule

// File: rtl/ldu_hazard_ctrl.sv
module ldu_hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned AW        = 5,
  parameter int unsigned NUM_SRC   = 2,
  parameter bit          BYPASS_EN = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       de2_valid_i,
  input  logic [NUM_SRC-1:0][AW-1:0] de2_src_i,
  input  logic [NUM_SRC-1:0]         de2_src_en_i,
  input  logic [4:0]                 stg_valid_i,
  input  logic [4:0]                 stg_we_i,
  input  logic [4:0]                 stg_ld_i,
  input  logic [4:0][AW-1:0]         stg_rd_i,
  output logic                       fetch_hold_o,
  output logic                       decode_hold_o,
  output logic                       rr_bubble_o,
  output logic [NUM_SRC-1:0][1:0]    ex_fwd_sel_o
);
  logic [NUM_SRC-1:0]      src_stall;
  logic [NUM_SRC-1:0][1:0] src_sel;
  logic                    hazard;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    fwd_sel_e sel_e;
    hzd_src_chk #(
      .AW        (AW),
      .BYPASS_EN (BYPASS_EN)
    ) u_src (
      .de_valid_i  (de2_valid_i),
      .src_en_i    (de2_src_en_i[s]),
      .src_i       (de2_src_i[s]),
      .stg_valid_i (stg_valid_i),
      .stg_we_i    (stg_we_i),
      .stg_ld_i    (stg_ld_i),
      .stg_rd_i    (stg_rd_i),
      .stall_o     (src_stall[s]),
      .sel_o       (sel_e)
    );
    assign src_sel[s] = sel_e;
  end

  assign hazard        = |src_stall;
  assign fetch_hold_o  = hazard;
  assign decode_hold_o = hazard;
  assign rr_bubble_o   = hazard;

  hzd_fwd_pipe #(
    .NUM_SRC (NUM_SRC)
  ) u_fwd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (~hazard),
    .sel_de_i (src_sel),
    .sel_ex_o (ex_fwd_sel_o)
  );
endmodule

// File: rtl/ldu_hazard_ctrl_sva.sv
module ldu_hazard_ctrl_sva #(
  parameter int unsigned AW        = 5,
  parameter int unsigned NUM_SRC   = 2,
  parameter bit          BYPASS_EN = 1'b1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       de2_valid_i,
  input logic [NUM_SRC-1:0][AW-1:0] de2_src_i,
  input logic [NUM_SRC-1:0]         de2_src_en_i,
  input logic [4:0]                 stg_valid_i,
  input logic [4:0]                 stg_we_i,
  input logic [4:0]                 stg_ld_i,
  input logic [4:0][AW-1:0]         stg_rd_i,
  input logic                       fetch_hold_o,
  input logic                       decode_hold_o,
  input logic                       rr_bubble_o,
  input logic [NUM_SRC-1:0][1:0]    ex_fwd_sel_o
);
  logic any_live_src;
  logic ld_rr_hit;
  logic any_live_ld;

  always_comb begin
    any_live_src = 1'b0;
    ld_rr_hit    = 1'b0;
    for (int s = 0; s < int'(NUM_SRC); s++) begin
      if (de2_valid_i && de2_src_en_i[s] && (de2_src_i[s] != '0)) begin
        any_live_src = 1'b1;
        if (stg_valid_i[0] && stg_we_i[0] && stg_ld_i[0] && (stg_rd_i[0] == de2_src_i[s]))
          ld_rr_hit = 1'b1;
      end
    end
    any_live_ld = |(stg_valid_i & stg_we_i & stg_ld_i);
  end

  AST_IDLE_DECODE_NO_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de2_valid_i |-> !rr_bubble_o); // R1

  AST_DEAD_SRC_NO_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_live_src |-> (!rr_bubble_o && !fetch_hold_o && !decode_hold_o)); // R1

  AST_LOAD_IN_RR_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rr_hit |-> (rr_bubble_o && fetch_hold_o && decode_hold_o)); // R2

  AST_BUBBLE_CARRIES_RF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_bubble_o |=> ##1 (ex_fwd_sel_o == '0)); // R9

  if (BYPASS_EN) begin : g_byp
    AST_ALU_ONLY_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !any_live_ld |-> !rr_bubble_o); // R6
  end else begin : g_nobyp
    AST_NOBYP_SEL_RF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      de2_valid_i |=> ##1 (ex_fwd_sel_o == '0)); // R10
  end
endmodule

bind ldu_hazard_ctrl ldu_hazard_ctrl_sva #(
  .AW        (AW),
  .NUM_SRC   (NUM_SRC),
  .BYPASS_EN (BYPASS_EN)
) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .de2_valid_i   (de2_valid_i),
  .de2_src_i     (de2_src_i),
  .de2_src_en_i  (de2_src_en_i),
  .stg_valid_i   (stg_valid_i),
  .stg_we_i      (stg_we_i),
  .stg_ld_i      (stg_ld_i),
  .stg_rd_i      (stg_rd_i),
  .fetch_hold_o  (fetch_hold_o),
  .decode_hold_o (decode_hold_o),
  .rr_bubble_o   (rr_bubble_o),
  .ex_fwd_sel_o  (ex_fwd_sel_o)
);

// File: tb/tb_ldu_hazard_ctrl.sv
module tb_ldu_hazard_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       v;
    logic       we;
    logic       ld;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic       e1;
    logic [4:0] rs2;
    logic       e2;
    logic [7:0] id;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // index 0: no bypass, index 1: bypass
  logic [4:0]      st_v  [2];
  logic [4:0]      st_we [2];
  logic [4:0]      st_ld [2];
  logic [4:0][4:0] st_rd [2];
  logic            dv    [2];
  logic [1:0][4:0] dsrc  [2];
  logic [1:0]      den   [2];
  logic            fh    [2];
  logic            dh    [2];
  logic            bub   [2];
  logic [1:0][1:0] fsel  [2];

  ins_t pipe [2][5];
  ins_t de2  [2];
  ins_t prog [16];
  int   plen;
  int   vectors = 0;
  int   fails   = 0;

  ldu_hazard_ctrl #(.AW(5), .NUM_SRC(2), .BYPASS_EN(1'b0)) dut_nobyp (
    .clk_i(clk), .rst_ni(rst_n), .de2_valid_i(dv[0]), .de2_src_i(dsrc[0]),
    .de2_src_en_i(den[0]), .stg_valid_i(st_v[0]), .stg_we_i(st_we[0]),
    .stg_ld_i(st_ld[0]), .stg_rd_i(st_rd[0]), .fetch_hold_o(fh[0]),
    .decode_hold_o(dh[0]), .rr_bubble_o(bub[0]), .ex_fwd_sel_o(fsel[0]));

  ldu_hazard_ctrl #(.AW(5), .NUM_SRC(2), .BYPASS_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .de2_valid_i(dv[1]), .de2_src_i(dsrc[1]),
    .de2_src_en_i(den[1]), .stg_valid_i(st_v[1]), .stg_we_i(st_we[1]),
    .stg_ld_i(st_ld[1]), .stg_rd_i(st_rd[1]), .fetch_hold_o(fh[1]),
    .decode_hold_o(dh[1]), .rr_bubble_o(bub[1]), .ex_fwd_sel_o(fsel[1]));

  function automatic ins_t mk(logic v, logic we, logic ld, logic [4:0] rd,
                              logic [4:0] rs1, logic e1, logic [4:0] rs2, logic e2,
                              logic [7:0] id);
    ins_t r;
    r.v = v; r.we = we; r.ld = ld; r.rd = rd;
    r.rs1 = rs1; r.e1 = e1; r.rs2 = rs2; r.e2 = e2; r.id = id;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_io();
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 5; k++) begin
        st_v[m][k]  = pipe[m][k].v;
        st_we[m][k] = pipe[m][k].we;
        st_ld[m][k] = pipe[m][k].ld;
        st_rd[m][k] = pipe[m][k].rd;
      end
      dv[m]      = de2[m].v;
      dsrc[m][0] = de2[m].rs1;
      dsrc[m][1] = de2[m].rs2;
      den[m]     = {de2[m].e2, de2[m].e1};
    end
  endtask

  task automatic clear_all();
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 5; k++) pipe[m][k] = '0;
      de2[m] = '0;
    end
    drive_io();
  endtask

  task automatic test_reset();
    #1;
    for (int m = 0; m < 2; m++) begin
      check("R9 reset sel", int'(fsel[m]), 0);
      check("R8 reset bubble", int'(bub[m]), 0);
    end
  endtask

  // one producer in stage k, one decode instruction, combinational stall check
  task automatic static_case(string req, ins_t p, int k, ins_t d, int exp_nb, int exp_b);
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      for (int j = 0; j < 5; j++) pipe[m][j] = '0;
      pipe[m][k] = p;
      de2[m] = d;
    end
    drive_io();
    #1;
    check({req, " nobyp"}, int'(bub[0]), exp_nb);
    check({req, " byp"}, int'(bub[1]), exp_b);
    clear_all();
  endtask

  // replay prog in both modes through a bench pipeline model
  task automatic replay(string rq_nb, int exp_nb, string rq_b, int exp_b,
                        logic [7:0] cid, int src, int exp_sel_b, string rq_sel);
    int cnt [2];
    int seen [2];
    int pc [2];
    bit stl [2];
    bit hold_bad;
    hold_bad = 1'b0;
    @(posedge clk); #1;
    for (int m = 0; m < 2; m++) begin
      cnt[m] = 0; seen[m] = -1; pc[m] = 1;
      for (int k = 0; k < 5; k++) pipe[m][k] = '0;
      de2[m] = prog[0];
    end
    drive_io();
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      for (int m = 0; m < 2; m++) begin
        stl[m] = bub[m];
        if (bub[m]) cnt[m]++;
        if (fh[m] !== bub[m] || dh[m] !== bub[m]) hold_bad = 1'b1;
        if (pipe[m][1].v && pipe[m][1].id == cid) seen[m] = int'(fsel[m][src]);
      end
      @(posedge clk); #1;
      for (int m = 0; m < 2; m++) begin
        for (int k = 4; k > 0; k--) pipe[m][k] = pipe[m][k-1];
        if (stl[m]) pipe[m][0] = '0;
        else begin
          pipe[m][0] = de2[m];
          if (pc[m] < plen) begin
            de2[m] = prog[pc[m]];
            pc[m]++;
          end else de2[m] = '0;
        end
      end
      drive_io();
    end
    check({rq_nb, " bubbles nobyp"}, cnt[0], exp_nb);
    check({rq_b, " bubbles byp"}, cnt[1], exp_b);
    check("R10 nobyp sel", seen[0], 0);
    check(rq_sel, seen[1], exp_sel_b);
    check("R8 hold equals bubble", int'(hold_bad), 0);
    clear_all();
  endtask

  ins_t nop1, nop2, nop3;

  initial begin
    nop1 = mk(1, 0, 0, 0, 0, 0, 0, 0, 8'd2);
    nop2 = mk(1, 0, 0, 0, 0, 0, 0, 0, 8'd3);
    nop3 = mk(1, 0, 0, 0, 0, 0, 0, 0, 8'd4);
    clear_all();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();

    // R2 R4: load in RR matching stalls both modes
    static_case("R2 load in RR", mk(1,1,1,5'd5,0,0,0,0,1), 0, mk(1,1,0,5'd4,5'd5,1,0,0,9), 1, 1);
    // R1: write enable low, invalid stage, register 0, decode invalid, source disabled
    static_case("R1 we low", mk(1,0,1,5'd5,0,0,0,0,1), 0, mk(1,1,0,5'd4,5'd5,1,0,0,9), 0, 0);
    static_case("R1 stage invalid", mk(0,1,1,5'd5,0,0,0,0,1), 0, mk(1,1,0,5'd4,5'd5,1,0,0,9), 0, 0);
    static_case("R1 reg zero", mk(1,1,1,5'd0,0,0,0,0,1), 0, mk(1,1,0,5'd4,5'd0,1,0,0,9), 0, 0);
    static_case("R1 decode invalid", mk(1,1,1,5'd5,0,0,0,0,1), 0, mk(0,1,0,5'd4,5'd5,1,0,0,9), 0, 0);
    static_case("R1 src disabled", mk(1,1,1,5'd5,0,0,0,0,1), 0, mk(1,1,0,5'd4,5'd5,0,5'd5,0,9), 0, 0);
    // R2: load in WB never stalls; R5: load in M2 stalls in bypass mode too
    static_case("R2 load in WB", mk(1,1,1,5'd5,0,0,0,0,1), 4, mk(1,1,0,5'd4,0,0,5'd5,1,9), 0, 0);
    static_case("R5 load in M2", mk(1,1,1,5'd5,0,0,0,0,1), 3, mk(1,1,0,5'd4,0,0,5'd5,1,9), 1, 1);

    // load then dependent add
    plen = 2;
    prog[0] = mk(1,1,1,5'd5,5'd2,1,0,0,1);
    prog[1] = mk(1,1,0,5'd4,5'd5,1,5'd3,1,9);
    replay("R2 load-use", 4, "R4 load-use", 2, 9, 0, 3, "R9 sel WB after load");

    // ALU then dependent ALU on second source
    plen = 2;
    prog[0] = mk(1,1,0,5'd5,5'd6,1,5'd7,1,1);
    prog[1] = mk(1,1,0,5'd8,5'd3,1,5'd5,1,9);
    replay("R3 alu-use", 2, "R6 alu-use", 0, 9, 1, 1, "R6 sel M1");

    plen = 3;
    prog[0] = mk(1,1,0,5'd5,5'd6,1,5'd7,1,1);
    prog[1] = nop1;
    prog[2] = mk(1,1,0,5'd8,5'd5,1,0,0,9);
    replay("R3 alu gap1", 1, "R6 alu gap1", 0, 9, 0, 2, "R6 sel M2");

    plen = 3;
    prog[0] = mk(1,1,1,5'd5,5'd2,1,0,0,1);
    prog[1] = nop1;
    prog[2] = mk(1,1,0,5'd8,5'd5,1,0,0,9);
    replay("R2 load gap1", 3, "R4 load gap1", 1, 9, 0, 3, "R4 sel WB gap1");

    plen = 4;
    prog[0] = mk(1,1,1,5'd5,5'd2,1,0,0,1);
    prog[1] = nop1;
    prog[2] = nop2;
    prog[3] = mk(1,1,0,5'd8,5'd5,1,0,0,9);
    replay("R2 load gap2", 2, "R4 load gap2", 0, 9, 0, 3, "R4 sel WB gap2");

    plen = 5;
    prog[0] = mk(1,1,1,5'd5,5'd2,1,0,0,1);
    prog[1] = nop1;
    prog[2] = nop2;
    prog[3] = nop3;
    prog[4] = mk(1,1,0,5'd8,5'd5,1,0,0,9);
    replay("R2 load gap3", 1, "R5 load gap3", 1, 9, 0, 0, "R5 sel RF");

    // youngest producer decides
    plen = 3;
    prog[0] = mk(1,1,1,5'd5,5'd2,1,0,0,1);
    prog[1] = mk(1,1,0,5'd5,5'd6,1,5'd7,1,2);
    prog[2] = mk(1,1,0,5'd8,5'd5,1,0,0,9);
    replay("R7 youngest", 2, "R7 youngest", 0, 9, 0, 1, "R7 sel M1");

    // register 0 dependence ignored
    plen = 2;
    prog[0] = mk(1,1,1,5'd0,5'd2,1,0,0,1);
    prog[1] = mk(1,1,0,5'd4,5'd0,1,5'd0,1,9);
    replay("R1 r0 load", 0, "R1 r0 load", 0, 9, 0, 0, "R1 sel r0");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule